// File: doc/BRIEF.md
# Cascade Token Controller for Chained FIFO Slices

This block sits beside one FIFO slice and lets several identical slices act as a single deeper FIFO. Two tokens travel around the chain of slices. A slice may accept writes only while it holds the write token, and reads only while it holds the read token. When the slice's local write position wraps past its last memory word, the write token leaves and a one-cycle pulse on `xout` tells the next slice to take it. When the local read position wraps, the read token leaves the same way. The receiving slice learns which token arrived from its own state. If it lacks the write token, the pulse brings the write token; otherwise it brings the read token.

The `cascade` strap selects the mode. In chained mode `xin` is wired to the previous slice's `xout`, and exactly one slice in the ring has `first_load` set, so it starts with both tokens. With `cascade` low the slice runs alone. Tokens play no part, `xin` should be tied low and is ignored, and `xout` repeats the core's half-full flag. The memory array and the full, empty and half-full flags belong to the FIFO core. This block only gates the strobes and drives the shared output. It also gates the core's retransmit request, which is allowed only when the slice runs alone.

Top module: `fifo_chain_ctrl`

## Requirements
- R1: At reset both tokens take the value of `first_load`, both local positions return to word 0, and in chained mode `xout` is low.
- R2: In chained mode `wr_en` is `wr_req` and not `full` and the write token is held. `rd_en` is `rd_req` and not `empty` and the read token is held. A strobe that is blocked does not advance the local position.
- R3: An accepted write at the last local word (position 2**ADDR_W-1) releases the write token at that clock edge, and the position wraps to 0. From the next cycle `wr_en` stays low until the token returns.
- R4: In chained mode, in the cycle after a write at the last word, `xout` is high, provided no earlier pulse is still being emitted.
- R5: An accepted read at the last word releases the read token and produces its own pulse. Every pulse is exactly one cycle high, and consecutive pulses have at least one low cycle between them. When both wrap in the same cycle C, the write pulse appears in cycle C+1 and the read pulse in cycle C+3.
- R6: In chained mode a high `xin` hands over the write token if the slice lacks it, and otherwise hands over the read token. The token takes effect from the next cycle.
- R7: `rt_en` follows `rt_req` in single mode and is forced low in chained mode.
- R8: In single mode the tokens are ignored, `wr_en` is `wr_req` and not `full`, and `rd_en` is `rd_req` and not `empty`. `xout` equals `half_full` in the same cycle, `xin` has no effect, and wrapping positions produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cascade | input | 1 | Strap: 1 = chained mode, 0 = single slice |
| first_load | input | 1 | Strap: this slice starts with both tokens |
| xin | input | 1 | Token pulse from the previous slice |
| wr_req | input | 1 | Write strobe for this slice |
| rd_req | input | 1 | Read strobe for this slice |
| full | input | 1 | Core full flag |
| empty | input | 1 | Core empty flag |
| half_full | input | 1 | Core half-full flag |
| rt_req | input | 1 | Retransmit request |
| wr_en | output | 1 | Gated write enable to the core |
| rd_en | output | 1 | Gated read enable to the core |
| rt_en | output | 1 | Gated retransmit to the core |
| xout | output | 1 | Token pulse to next slice, or half-full in single mode |

## Verification
A lost or duplicated token shows at once: `wr_en` or `rd_en` goes high or stays low on the very next strobe. A local position that is off by one moves the `xout` pulse by one cycle or more, so it appears one access early or late. A broken pulse queue shows within three cycles of a shared wrap, as a merged pulse, a missing pulse or a swapped order. A mode mux error shows in the same cycle as a mismatch between `xout` and `half_full`, or as a retransmit that should have been blocked.

// File: rtl/fifo_chain_ctrl.sv
module fifo_chain_ctrl #(
  parameter int ADDR_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cascade,
  input  logic first_load,
  input  logic xin,
  input  logic wr_req,
  input  logic rd_req,
  input  logic full,
  input  logic empty,
  input  logic half_full,
  input  logic rt_req,
  output logic wr_en,
  output logic rd_en,
  output logic rt_en,
  output logic xout
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  logic has_wr, has_rd, xo_q, pend_w, pend_r;
  logic [ADDR_W-1:0] wp, rp;
  logic hit_w, hit_r, want_w, want_r, emit, emit_w, emit_r;

  assign wr_en = wr_req & ~full  & (~cascade | has_wr);
  assign rd_en = rd_req & ~empty & (~cascade | has_rd);
  assign rt_en = rt_req & ~cascade;
  assign xout  = cascade ? xo_q : half_full;

  assign hit_w  = cascade & wr_en & (wp == LAST);
  assign hit_r  = cascade & rd_en & (rp == LAST);
  assign want_w = pend_w | hit_w;
  assign want_r = pend_r | hit_r;
  assign emit   = ~xo_q & (want_w | want_r);
  assign emit_w = emit & want_w;
  assign emit_r = emit & ~want_w & want_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      has_wr <= first_load;
      has_rd <= first_load;
      wp     <= '0;
      rp     <= '0;
      xo_q   <= 1'b0;
      pend_w <= 1'b0;
      pend_r <= 1'b0;
    end else begin
      xo_q   <= emit;
      pend_w <= want_w & ~emit_w;
      pend_r <= want_r & ~emit_r;
      if (wr_en) wp <= wp + 1'b1;
      if (rd_en) rp <= rp + 1'b1;
      if (cascade) begin
        has_wr <= (has_wr & ~hit_w) | (xin & ~has_wr);
        has_rd <= (has_rd & ~hit_r) | (xin & has_wr);
      end
    end
  end

  a_r3_release_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade && wr_en && wp == LAST) |=> !wr_en);

  a_r5_release_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade && rd_en && rp == LAST) |=> !rd_en);

  a_r4_pulse_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade && wr_en && wp == LAST && !xout) |=> xout);

  a_r5_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade && xout) |=> !xout);

  a_r6_token_needs_xin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(has_wr) |-> $past(xin));

  a_r8_no_token_change_alone: assert property (@(posedge clk) disable iff (!rst_n)
    !cascade |=> $stable(has_wr) && $stable(has_rd));
endmodule

// File: tb/fifo_chain_ctrl_test.sv
module fifo_chain_ctrl_test;
  typedef struct {
    logic we, re, xo, rt;
    string tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cascade = 1'b1, first_load = 1'b0, xin = 1'b0;
  logic wr_req = 1'b0, rd_req = 1'b0, full = 1'b0, empty = 1'b0;
  logic half_full = 1'b0, rt_req = 1'b0;
  logic wr_en, rd_en, rt_en, xout;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  fifo_chain_ctrl #(.ADDR_W(2)) uut (
    .clk(clk), .rst_n(rst_n), .cascade(cascade), .first_load(first_load),
    .xin(xin), .wr_req(wr_req), .rd_req(rd_req), .full(full), .empty(empty),
    .half_full(half_full), .rt_req(rt_req),
    .wr_en(wr_en), .rd_en(rd_en), .rt_en(rt_en), .xout(xout)
  );

  task automatic step(input logic w, r, x, f, e, hf, rt,
                      input logic ew, er, ex, ert, input string tag);
    exp_t it;
    @(negedge clk);
    wr_req = w; rd_req = r; xin = x; full = f; empty = e;
    half_full = hf; rt_req = rt;
    it.we = ew; it.re = er; it.xo = ex; it.rt = ert; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic do_reset(input logic cas, input logic fl);
    @(negedge clk);
    rst_n = 1'b0; cascade = cas; first_load = fl;
    wr_req = 0; rd_req = 0; xin = 0; full = 0; empty = 0; half_full = 0; rt_req = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        checks++;
        if ({wr_en, rd_en, xout, rt_en} !== {it.we, it.re, it.xo, it.rt}) begin
          errors++;
          $display("FAIL %s: we/re/xo/rt actual=%b%b%b%b expected=%b%b%b%b",
                   it.tag, wr_en, rd_en, xout, rt_en, it.we, it.re, it.xo, it.rt);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: chained slice without first_load owns no token
    do_reset(1'b1, 1'b0);
    step(1,1,0,0,0,0,1, 0,0,0,0, "R1 no token / R7 rt blocked");
    step(0,1,0,0,0,0,0, 0,0,0,0, "R1 no read token");

    do_reset(1'b1, 1'b1);
    step(0,0,0,0,0,1,0, 0,0,0,0, "R1 idle, xout ignores half_full");
    step(1,0,0,1,0,0,0, 0,0,0,0, "R2 full blocks write");
    step(0,1,0,0,1,0,0, 0,0,0,0, "R2 empty blocks read");
    for (int i = 0; i < 3; i++) step(1,0,0,0,0,0,0, 1,0,0,0, "R2 write accepted");
    step(1,0,0,0,0,0,0, 1,0,0,0, "R3 write at last word");
    step(1,0,0,0,0,0,0, 0,0,1,0, "R3 token gone, R4 pulse");
    step(1,0,0,0,0,0,0, 0,0,0,0, "R5 pulse one cycle");
    step(0,0,0,0,0,0,1, 0,0,0,0, "R7 rt blocked in chain");
    for (int i = 0; i < 3; i++) step(0,1,0,0,0,0,0, 0,1,0,0, "R2 read accepted");
    step(0,1,0,0,0,0,0, 0,1,0,0, "R5 read at last word");
    step(0,1,0,0,0,0,0, 0,0,1,0, "R5 read pulse, token gone");
    step(0,1,0,0,0,0,0, 0,0,0,0, "R5 pulse one cycle");
    step(1,0,1,0,0,0,0, 0,0,0,0, "R6 xin cycle, token not yet");
    step(1,0,0,0,0,0,0, 1,0,0,0, "R6 write token taken");
    step(0,1,1,0,0,0,0, 0,0,0,0, "R6 second xin cycle");
    step(0,1,0,0,0,0,0, 0,1,0,0, "R6 read token taken");
    for (int i = 0; i < 2; i++) step(1,1,0,0,0,0,0, 1,1,0,0, "R2 both accepted");
    step(1,1,0,0,0,0,0, 1,1,0,0, "R5 both wrap");
    step(1,1,0,0,0,0,0, 0,0,1,0, "R5 write pulse first");
    step(0,0,0,0,0,0,0, 0,0,0,0, "R5 gap");
    step(0,0,0,0,0,0,0, 0,0,1,0, "R5 read pulse second");
    step(0,0,0,0,0,0,0, 0,0,0,0, "R5 pulse ends");

    do_reset(1'b0, 1'b0);
    step(1,0,0,0,0,1,1, 1,0,1,1, "R8 single write, half_full / R7 rt");
    step(1,0,0,1,0,0,0, 0,0,0,0, "R8 full blocks write");
    for (int i = 0; i < 5; i++) step(1,0,0,0,0,0,0, 1,0,0,0, "R8 no pulse on wrap");
    step(0,1,1,0,0,0,0, 0,1,0,0, "R8 xin ignored, read");
    step(0,0,0,0,0,1,0, 0,0,1,0, "R8 xout follows half_full");
    step(0,0,0,0,0,0,0, 0,0,0,0, "R8 xout follows half_full low");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule